// File: doc/BRIEF.md
# Image Sensor Bring-Up Sequencer

This controller brings an image sensor up after power-on. It sends every access through a register-access master, which bridges a simple request/acknowledge port onto the sensor's serial control bus. A single start pulse launches the whole run. The controller turns the bus on and sets the sensor's bus address. It then soft-resets the sensor, waits, and checks that the sensor reports the expected manufacturer. Next it captures the product identity. Last, it writes a parameterised list of register/value pairs into the sensor.

Each sensor access has a fixed pattern on the master port. The controller stages the register index and, for a write, the value in the master's window. It then writes an operation code and polls a status location until the access completes. The number of polls is bounded. After a long final wait the run ends with a done flag or an error flag. Each flag stays set until the next start.

Top module: `sensor_bringup_seq`

## Requirements
- R1: After start, the first two port transactions are master writes of 0x1E to window offset 2 (bus enable) and of 0x60 to offset 3 (sensor bus address). These are followed by a sensor write of 0x80 to sensor register 0x12.
- R2: A sensor write writes the register index to offset 4, then the value to offset 5, then operation code 0x05 to offset 0. It then reads status at offset 1. The write succeeds only if the final status is 0x04. The port request holds its index, direction and data until it is acknowledged.
- R3: A sensor read writes the register index to offset 8, then operation code 0x70 to offset 0, then polls status at offset 1. The read succeeds only if the final status is 0x01, and the data is then read from offset 9. Any other nonzero status is an error.
- R4: Status is polled again only while it reads zero, and at most MAX_POLLS reads are made per access. If all MAX_POLLS reads return zero, the access fails and the run ends with err_o set.
- R5: After the reset write completes, no port request is made for at least WAIT_CYCLES cycles.
- R6: Sensor register 0x1C is read next and must hold 0x7F. Sensor register 0x1D is read after it and must hold 0xA2. At the first mismatch the run ends with err_o, and no further access is made.
- R7: Sensor registers 0x0A and 0x0B are then read. They appear on pid_o as the high and low byte.
- R8: Table entries (bits [15:8] register, [7:0] value, entry 0 at the lowest bits) are written in index order. The walk stops at the first entry equal to 0xFFFF, or after TBL_DEPTH entries. An entry with only one byte equal to 0xFF is still written.
- R9: A failed table write stops the walk immediately and sets err_o.
- R10: done_o is set no earlier than WAIT_CYCLES cycles after the last table access completes.
- R11: done_o and err_o are never set together. Each stays set until a start pulse in the idle state clears both. A start pulse during a run is ignored.
- R12: After reset, done_o, err_o and bus_req_o are low and pid_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| done_o | output | 1 | Sticky success flag |
| err_o | output | 1 | Sticky failure flag |
| pid_o | output | 16 | Captured product identity |
| bus_req_o | output | 1 | Request to the register-access master |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_idx_o | output | 4 | Master window offset |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Acknowledge; read data is valid with it |
| bus_rdata_i | input | 8 | Read data |

## Verification
The bench targets the poll bound at both edges. With MAX_POLLS-1 zero statuses the access must still succeed; a design with an off-by-one limit would abort a healthy sensor. With MAX_POLLS zero statuses exactly that many reads must occur before failure; an unbounded poll loop would hang instead. It also places 0xFF in only one byte of a table entry, which a careless terminator test would treat as the end of the table. Finally it injects errors in the manufacturer check, in a product-ID read and in a table write. After each one the access logs must stop at once, because a design that fails to abort would keep writing to a sensor it has rejected.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam logic [3:0] OFF_OP    = 4'd0;
  localparam logic [3:0] OFF_STAT  = 4'd1;
  localparam logic [3:0] OFF_EN    = 4'd2;
  localparam logic [3:0] OFF_SLV   = 4'd3;
  localparam logic [3:0] OFF_TXIDX = 4'd4;
  localparam logic [3:0] OFF_TXVAL = 4'd5;
  localparam logic [3:0] OFF_RXIDX = 4'd8;
  localparam logic [3:0] OFF_RXVAL = 4'd9;

  localparam logic [7:0] OP_WR     = 8'h05;
  localparam logic [7:0] OP_RD     = 8'h70;
  localparam logic [7:0] STAT_WROK = 8'h04;
  localparam logic [7:0] STAT_RDOK = 8'h01;

  localparam logic [7:0] BUS_ON    = 8'h1E;
  localparam logic [7:0] SLV_ADDR  = 8'h60;
  localparam logic [7:0] RST_REG   = 8'h12;
  localparam logic [7:0] RST_VAL   = 8'h80;
  localparam logic [7:0] MID_HREG  = 8'h1C;
  localparam logic [7:0] MID_LREG  = 8'h1D;
  localparam logic [7:0] MID_HVAL  = 8'h7F;
  localparam logic [7:0] MID_LVAL  = 8'hA2;
  localparam logic [7:0] PID_HREG  = 8'h0A;
  localparam logic [7:0] PID_LREG  = 8'h0B;

  typedef enum logic [1:0] {K_RAW, K_WR, K_RD} acc_kind_e;
endpackage

// File: rtl/sbs_wait_timer.sv
module sbs_wait_timer #(
  parameter int CYCLES = 1250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic idle_o
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/sbs_init_rom.sv
module sbs_init_rom #(
  parameter int DEPTH = 8,
  parameter int IW    = 4,
  parameter logic [DEPTH*16-1:0] TABLE = '1
) (
  input  logic [IW-1:0] idx_i,
  output logic [7:0]    reg_o,
  output logic [7:0]    val_o,
  output logic          end_o
);
  localparam int SLOTS = 1 << IW;
  logic [15:0] ent [SLOTS];

  // slots past DEPTH read as the terminator
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < DEPTH) begin : g_fill
      assign ent[g] = TABLE[g*16 +: 16];
    end else begin : g_pad
      assign ent[g] = 16'hFFFF;
    end
  end

  assign reg_o = ent[idx_i][15:8];
  assign val_o = ent[idx_i][7:0];
  assign end_o = (ent[idx_i] == 16'hFFFF);
endmodule

// File: rtl/sbs_access.sv
module sbs_access
  import sbs_pkg::*;
#(
  parameter int MAX_POLLS = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  acc_kind_e  cmd_kind_i,
  input  logic [7:0] cmd_addr_i,
  input  logic [7:0] cmd_data_i,
  output logic       done_o,
  output logic       fail_o,
  output logic [7:0] rdata_o,
  output logic       bus_req_o,
  output logic       bus_we_o,
  output logic [3:0] bus_idx_o,
  output logic [7:0] bus_wdata_o,
  input  logic       bus_ack_i,
  input  logic [7:0] bus_rdata_i
);
  localparam int PW = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {E_IDLE, E_IDX, E_VAL, E_OP, E_POLL, E_RDV, E_END} est_e;
  est_e       st_q;
  acc_kind_e  kind_q;
  logic [7:0] addr_q, data_q, rd_q;
  logic [PW-1:0] cnt_q, cnt_nxt;
  logic       fail_q;
  logic [7:0] exp_stat;

  assign cnt_nxt  = cnt_q + 1'b1;
  assign exp_stat = (kind_q == K_RD) ? STAT_RDOK : STAT_WROK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= E_IDLE; kind_q <= K_RAW; addr_q <= '0; data_q <= '0;
      rd_q <= '0; cnt_q <= '0; fail_q <= 1'b0;
    end else begin
      case (st_q)
        E_IDLE: if (cmd_valid_i) begin
          kind_q <= cmd_kind_i; addr_q <= cmd_addr_i; data_q <= cmd_data_i;
          fail_q <= 1'b0; st_q <= E_IDX;
        end
        E_IDX: if (bus_ack_i)
          st_q <= (kind_q == K_RAW) ? E_END : (kind_q == K_WR) ? E_VAL : E_OP;
        E_VAL: if (bus_ack_i) st_q <= E_OP;
        E_OP: if (bus_ack_i) begin
          cnt_q <= '0; st_q <= E_POLL;
        end
        E_POLL: if (bus_ack_i) begin
          cnt_q <= cnt_nxt;
          if (bus_rdata_i == 8'h00 && cnt_nxt < PW'(MAX_POLLS)) st_q <= E_POLL;
          else if (bus_rdata_i == exp_stat) st_q <= (kind_q == K_RD) ? E_RDV : E_END;
          else begin fail_q <= 1'b1; st_q <= E_END; end
        end
        E_RDV: if (bus_ack_i) begin
          rd_q <= bus_rdata_i; st_q <= E_END;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_we_o = 1'b1; bus_idx_o = OFF_OP; bus_wdata_o = 8'h00;
    case (st_q)
      E_IDX: begin
        bus_idx_o   = (kind_q == K_RAW) ? addr_q[3:0] : (kind_q == K_WR) ? OFF_TXIDX : OFF_RXIDX;
        bus_wdata_o = (kind_q == K_RAW) ? data_q : addr_q;
      end
      E_VAL: begin bus_idx_o = OFF_TXVAL; bus_wdata_o = data_q; end
      E_OP:  bus_wdata_o = (kind_q == K_RD) ? OP_RD : OP_WR;
      E_POLL: begin bus_we_o = 1'b0; bus_idx_o = OFF_STAT; end
      E_RDV:  begin bus_we_o = 1'b0; bus_idx_o = OFF_RXVAL; end
      default: ;
    endcase
  end

  assign bus_req_o = (st_q inside {E_IDX, E_VAL, E_OP, E_POLL, E_RDV});
  assign done_o    = (st_q == E_END);
  assign fail_o    = fail_q;
  assign rdata_o   = rd_q;

  // R4
  poll_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == E_POLL) |-> (cnt_q < PW'(MAX_POLLS)));
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_idx_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));
endmodule

// File: rtl/sensor_bringup_seq.sv
module sensor_bringup_seq
  import sbs_pkg::*;
#(
  parameter int WAIT_CYCLES = 1250000,
  parameter int MAX_POLLS   = 50,
  parameter int TBL_DEPTH   = 8,
  parameter logic [TBL_DEPTH*16-1:0] INIT_TABLE =
    {16'h0000, 16'h0000, 16'hFFFF, 16'h1365, 16'h10FF, 16'hFF10, 16'h3B01, 16'h1180}
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] pid_o,
  output logic        bus_req_o,
  output logic        bus_we_o,
  output logic [3:0]  bus_idx_o,
  output logic [7:0]  bus_wdata_o,
  input  logic        bus_ack_i,
  input  logic [7:0]  bus_rdata_i
);
  localparam int TIW = $clog2(TBL_DEPTH + 1);

  typedef enum logic [3:0] {
    T_IDLE, T_EN, T_ADR, T_RST, T_W1, T_MIDH, T_MIDL, T_PIDH, T_PIDL, T_TCHK, T_TWR, T_W2
  } tst_e;

  tst_e           st_q;
  logic           issue_q, done_q, err_q;
  logic [15:0]    pid_q;
  logic [TIW-1:0] tbl_idx_q;

  acc_kind_e  cmd_kind;
  logic [7:0] cmd_addr, cmd_data;
  logic       acc_done, acc_fail;
  logic [7:0] acc_rdata;
  logic [7:0] tbl_reg, tbl_val;
  logic       tbl_term, tbl_end;
  logic       tmr_load, tmr_idle;

  sbs_init_rom #(.DEPTH(TBL_DEPTH), .IW(TIW), .TABLE(INIT_TABLE)) u_rom (
    .idx_i(tbl_idx_q), .reg_o(tbl_reg), .val_o(tbl_val), .end_o(tbl_term)
  );

  assign tbl_end  = tbl_term || (tbl_idx_q == TIW'(TBL_DEPTH));
  assign tmr_load = (st_q == T_RST && acc_done && !acc_fail) || (st_q == T_TCHK && tbl_end);

  sbs_wait_timer #(.CYCLES(WAIT_CYCLES)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .idle_o(tmr_idle)
  );

  always_comb begin
    cmd_kind = K_RAW; cmd_addr = 8'h00; cmd_data = 8'h00;
    case (st_q)
      T_EN:   begin cmd_addr = {4'h0, OFF_EN};  cmd_data = BUS_ON;   end
      T_ADR:  begin cmd_addr = {4'h0, OFF_SLV}; cmd_data = SLV_ADDR; end
      T_RST:  begin cmd_kind = K_WR; cmd_addr = RST_REG; cmd_data = RST_VAL; end
      T_MIDH: begin cmd_kind = K_RD; cmd_addr = MID_HREG; end
      T_MIDL: begin cmd_kind = K_RD; cmd_addr = MID_LREG; end
      T_PIDH: begin cmd_kind = K_RD; cmd_addr = PID_HREG; end
      T_PIDL: begin cmd_kind = K_RD; cmd_addr = PID_LREG; end
      T_TWR:  begin cmd_kind = K_WR; cmd_addr = tbl_reg; cmd_data = tbl_val; end
      default: ;
    endcase
  end

  sbs_access #(.MAX_POLLS(MAX_POLLS)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_valid_i(issue_q), .cmd_kind_i(cmd_kind), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .done_o(acc_done), .fail_o(acc_fail), .rdata_o(acc_rdata),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_idx_o(bus_idx_o), .bus_wdata_o(bus_wdata_o),
    .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= T_IDLE; issue_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      pid_q <= '0; tbl_idx_q <= '0;
    end else begin
      issue_q <= 1'b0;
      case (st_q)
        T_IDLE: if (start_i) begin
          done_q <= 1'b0; err_q <= 1'b0; st_q <= T_EN; issue_q <= 1'b1;
        end
        T_W1: if (tmr_idle) begin st_q <= T_MIDH; issue_q <= 1'b1; end
        T_TCHK: if (tbl_end) st_q <= T_W2;
                else begin st_q <= T_TWR; issue_q <= 1'b1; end
        T_W2: if (tmr_idle) begin done_q <= 1'b1; st_q <= T_IDLE; end
        default: if (acc_done) begin
          if (acc_fail) begin
            err_q <= 1'b1; st_q <= T_IDLE;
          end else begin
            case (st_q)
              T_EN:  begin st_q <= T_ADR; issue_q <= 1'b1; end
              T_ADR: begin st_q <= T_RST; issue_q <= 1'b1; end
              T_RST: st_q <= T_W1;
              T_MIDH: if (acc_rdata != MID_HVAL) begin err_q <= 1'b1; st_q <= T_IDLE; end
                      else begin st_q <= T_MIDL; issue_q <= 1'b1; end
              T_MIDL: if (acc_rdata != MID_LVAL) begin err_q <= 1'b1; st_q <= T_IDLE; end
                      else begin st_q <= T_PIDH; issue_q <= 1'b1; end
              T_PIDH: begin pid_q[15:8] <= acc_rdata; st_q <= T_PIDL; issue_q <= 1'b1; end
              T_PIDL: begin pid_q[7:0] <= acc_rdata; tbl_idx_q <= '0; st_q <= T_TCHK; end
              T_TWR:  begin tbl_idx_q <= tbl_idx_q + 1'b1; st_q <= T_TCHK; end
              default: st_q <= T_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;
  assign pid_o  = pid_q;

  // R5
  wait_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_W1 || st_q == T_W2) |-> !bus_req_o);
  // R11
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  // R6
  mid_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_MIDH && acc_done && !acc_fail && acc_rdata != MID_HVAL) |=> (err_o && st_q == T_IDLE));
  // R10
  done_after_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(st_q) == T_W2));
  // R8
  tbl_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_TCHK && tbl_end) |=> (st_q == T_W2));
endmodule

// File: tb/tb_sensor_bringup_seq.sv
module tb_sensor_bringup_seq;
  localparam int WAITC = 40;
  localparam int MAXP  = 8;
  localparam int DEPTH = 8;
  localparam logic [DEPTH*16-1:0] TBL =
    {16'h0000, 16'h5555, 16'hFFFF, 16'h1365, 16'h10FF, 16'hFF10, 16'h3B01, 16'h1180};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ack = 1'b0;
  logic [7:0] rdata = 8'h00;
  logic done, err, req, we;
  logic [15:0] pid;
  logic [3:0] idx;
  logic [7:0] wdata;

  always #4 clk = ~clk;

  sensor_bringup_seq #(.WAIT_CYCLES(WAITC), .MAX_POLLS(MAXP), .TBL_DEPTH(DEPTH), .INIT_TABLE(TBL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_o(done), .err_o(err), .pid_o(pid),
    .bus_req_o(req), .bus_we_o(we), .bus_idx_o(idx), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;

  // bridge + sensor model
  logic [7:0] smem [256];
  logic [7:0] txidx, txval, rxidx, rxval, code;
  bit tx_i_set, tx_v_set, rx_i_set;
  int busy_left, busy_cfg, stuck_reg, stuck_cnt, bad_reg, dly;
  int n_raw, n_wr, n_rd, stat_reads, frame_err, last_ack_cyc, gap_w1;
  logic [3:0] raw_idx [8];
  logic [7:0] raw_dat [8];
  logic [7:0] wr_reg [32];
  logic [7:0] wr_val [32];
  logic [7:0] rd_reg [16];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: run hung, cycle %0d expected below %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic model_write();
    case (idx)
      4'd2, 4'd3: begin
        if (n_raw < 8) begin raw_idx[n_raw] = idx; raw_dat[n_raw] = wdata; end
        n_raw++;
      end
      4'd4: begin txidx = wdata; tx_i_set = 1; end
      4'd5: begin txval = wdata; tx_v_set = 1; end
      4'd8: begin rxidx = wdata; rx_i_set = 1; end
      4'd0: begin
        stat_reads = 0;
        if (wdata == 8'h05) begin
          if (!(tx_i_set && tx_v_set)) frame_err++;
          if (n_wr < 32) begin wr_reg[n_wr] = txidx; wr_val[n_wr] = txval; end
          n_wr++;
          busy_left = (int'(txidx) == stuck_reg) ? stuck_cnt : busy_cfg;
          code = (int'(txidx) == bad_reg) ? 8'h02 : 8'h04;
          if (code == 8'h04) smem[txidx] = txval;
        end else if (wdata == 8'h70) begin
          if (!rx_i_set) frame_err++;
          if (n_rd < 16) rd_reg[n_rd] = rxidx;
          n_rd++;
          rxval = smem[rxidx];
          busy_left = (int'(rxidx) == stuck_reg) ? stuck_cnt : busy_cfg;
          code = (int'(rxidx) == bad_reg) ? 8'h02 : 8'h01;
        end else frame_err++;
        tx_i_set = 0; tx_v_set = 0; rx_i_set = 0;
      end
      default: frame_err++;
    endcase
  endtask

  always @(negedge clk) begin
    ack = 1'b0;
    if (rst_n && req) begin
      if (dly < 0) begin
        dly = int'($urandom % 3);
        if (idx == 4'd8 && n_rd == 0 && n_wr == 1) gap_w1 = cyc - last_ack_cyc;
      end
      if (dly == 0) begin
        ack = 1'b1; dly = -1; last_ack_cyc = cyc;
        if (we) model_write();
        else if (idx == 4'd1) begin
          stat_reads++;
          if (busy_left > 0) begin rdata = 8'h00; busy_left--; end
          else rdata = code;
        end else if (idx == 4'd9) rdata = rxval;
        else rdata = 8'hEE;
      end else dly--;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_raw = 0; n_wr = 0; n_rd = 0; stat_reads = 0; frame_err = 0; gap_w1 = -1;
    tx_i_set = 0; tx_v_set = 0; rx_i_set = 0;
  endtask

  // expected table walk length
  function automatic int exp_walk();
    for (int i = 0; i < DEPTH; i++)
      if (TBL[i*16 +: 16] == 16'hFFFF) return i;
    return DEPTH;
  endfunction

  int done_gap;
  task automatic run_seq();
    int t;
    clear_logs();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && !err && t < 20000) begin @(negedge clk); t++; end
    done_gap = cyc - last_ack_cyc;
    chk(t < 20000, "R11 run ended", t, 20000);
  endtask

  task automatic check_ok(input string tag, input logic [15:0] exp_pid);
    int nt;
    nt = exp_walk();
    chk(done === 1'b1 && err === 1'b0, {tag, " R10 done"}, {done, err}, 2'b10);
    chk(n_raw == 2 && raw_idx[0] == 4'd2 && raw_dat[0] == 8'h1E && raw_idx[1] == 4'd3 && raw_dat[1] == 8'h60,
        {tag, " R1 bridge setup"}, {raw_idx[0], raw_dat[0]}, 12'h21E);
    chk(wr_reg[0] == 8'h12 && wr_val[0] == 8'h80, {tag, " R1 reset write"}, {wr_reg[0], wr_val[0]}, 16'h1280);
    chk(frame_err == 0, {tag, " R2 R3 access framing"}, frame_err, 0);
    chk(n_rd == 4 && rd_reg[0] == 8'h1C && rd_reg[1] == 8'h1D && rd_reg[2] == 8'h0A && rd_reg[3] == 8'h0B,
        {tag, " R6 R7 read order"}, n_rd, 4);
    chk(pid == exp_pid, {tag, " R7 pid"}, pid, exp_pid);
    chk(n_wr == nt + 1, {tag, " R8 table length"}, n_wr - 1, nt);
    for (int i = 0; i < nt; i++)
      chk({wr_reg[i+1], wr_val[i+1]} == TBL[i*16 +: 16], {tag, " R8 table entry"},
          {wr_reg[i+1], wr_val[i+1]}, TBL[i*16 +: 16]);
    chk(gap_w1 >= WAITC, {tag, " R5 reset wait"}, gap_w1, WAITC);
    chk(done_gap >= WAITC, {tag, " R10 final wait"}, done_gap, WAITC);
  endtask

  initial begin
    void'($urandom(32'd7531));
    for (int i = 0; i < 256; i++) smem[i] = 8'h00;
    smem[8'h1C] = 8'h7F; smem[8'h1D] = 8'hA2; smem[8'h0A] = 8'h96; smem[8'h0B] = 8'h52;
    busy_cfg = 0; stuck_reg = -1; stuck_cnt = 0; bad_reg = -1; dly = -1;
    busy_left = 0; code = 8'h00; last_ack_cyc = 0;
    clear_logs();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(done === 1'b0 && err === 1'b0 && req === 1'b0 && pid === 16'h0, "R12 reset state",
        {done, err, req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed nominal run
    run_seq();
    check_ok("nominal", 16'h9652);
    repeat (60) @(negedge clk);
    chk(done === 1'b1, "R11 done sticky", done, 1);

    // constrained random runs
    for (int r = 0; r < 6; r++) begin
      logic [7:0] h, l;
      h = 8'($urandom); l = 8'($urandom);
      smem[8'h0A] = h; smem[8'h0B] = l;
      busy_cfg = int'($urandom % MAXP);
      run_seq();
      check_ok("random", {h, l});
    end
    busy_cfg = 0;

    // R4 poll bound: MAXP-1 zero statuses still succeed
    stuck_reg = 8'h12; stuck_cnt = MAXP - 1;
    run_seq();
    chk(done === 1'b1 && err === 1'b0, "R4 last poll succeeds", {done, err}, 2'b10);
    // R4 poll bound: MAXP zero statuses fail after exactly MAXP reads
    stuck_cnt = MAXP;
    run_seq();
    chk(err === 1'b1 && done === 1'b0, "R4 poll exhaustion error", {done, err}, 2'b01);
    chk(stat_reads == MAXP, "R4 status read count", stat_reads, MAXP);
    chk(n_rd == 0, "R4 no access after failure", n_rd, 0);
    stuck_reg = -1;
    repeat (50) @(negedge clk);
    chk(err === 1'b1, "R11 err sticky", err, 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(err === 1'b0 && done === 1'b0, "R11 start clears flags", {done, err}, 0);
    while (!done && !err) @(negedge clk);
    chk(done === 1'b1, "R11 rerun completes", done, 1);

    // R2 wrong nonzero write status
    bad_reg = 8'h12; busy_cfg = 2;
    run_seq();
    chk(err === 1'b1 && stat_reads == 3, "R2 bad write status", stat_reads, 3);
    busy_cfg = 0;

    // R6 manufacturer mismatch, high then low byte
    bad_reg = -1; smem[8'h1C] = 8'h7E;
    run_seq();
    chk(err === 1'b1 && n_rd == 1, "R6 high id mismatch", n_rd, 1);
    smem[8'h1C] = 8'h7F; smem[8'h1D] = 8'hA3;
    run_seq();
    chk(err === 1'b1 && n_rd == 2 && n_wr == 1, "R6 low id mismatch", n_rd, 2);
    smem[8'h1D] = 8'hA2;

    // R3 read with wrong completion code
    bad_reg = 8'h0A;
    run_seq();
    chk(err === 1'b1 && n_rd == 3 && n_wr == 1, "R3 bad read status", n_rd, 3);

    // R9 failed table write stops walk (entry 1, register 0x3B)
    bad_reg = 8'h3B;
    run_seq();
    chk(err === 1'b1 && done === 1'b0, "R9 table error flag", {done, err}, 2'b01);
    chk(n_wr == 3 && wr_reg[2] == 8'h3B, "R9 walk stopped", n_wr, 3);
    bad_reg = -1;

    // R11 start during a run is ignored
    clear_logs();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && !err) @(negedge clk);
    chk(done === 1'b1 && n_raw == 2 && n_wr == exp_walk() + 1, "R11 mid-run start ignored", n_raw, 2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule